// File: doc/BRIEF.md
# Backoff Test-and-Test-and-Set Lock Requester

This block acquires a shared spin lock for one processor. The core raises an acquire request. The engine then polls the lock word in memory with ordinary reads for as long as the lock reads as held. When a read finds the lock free, the engine does not claim it at once. It waits a delay, reads a second time, and issues an atomic test-and-set only if that second read still finds the lock free. A test-and-set that finds the lock already taken counts as a failure, and the engine goes back to polling.

Two sources supply the delay. In static mode each processor is given its own fixed wait through a configuration input, so processors can be staggered or ranked. In dynamic mode the engine draws a pseudo-random wait below a power-of-two bound. The bound doubles after every failed test-and-set, stops at a cap, and drops back to its minimum once the lock is won. An optional post-access mode also puts a wait after every busy read and after every failed test-and-set, which lowers the polling rate on the shared bus.

When the engine wins the lock it raises grant and holds it until the core asks for a release. A release sends one store that marks the lock free, and the engine then goes back to idle.

Top module: `ttas_acquire_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, grant and mem_req are both 0.
- R2: While reads return busy (mem_busy=1), the engine issues only read operations (mem_op=0) and never a test-and-set (mem_op=1).
- R3: After a read returns free (mem_busy=0), the engine waits and then issues a second read. A test-and-set follows only if that second read also returns free. If the second read returns busy, polling resumes.
- R4: When cfg_post=1, a busy read or a failed test-and-set is followed by a delay of d+1 idle cycles before the next read. The next request therefore starts d+2 cycles after the completing cycle.
- R5: When cfg_dyn=0 the delay d equals cfg_slot. The second read's request starts exactly cfg_slot+2 cycles after the cycle in which the free read completed.
- R6: When cfg_dyn=1 the delay d is the low DW bits of a 16-bit LFSR ANDed with (2^e - 1). The LFSR shifts left every cycle out of reset, taking feedback bit15^bit13^bit12^bit10 into bit 0, from the seed 16'hACE1.
- R7: The exponent e is 1 after reset. It increases by 1 on each failed test-and-set, stops at 4, and returns to 1 when a test-and-set succeeds.
- R8: Grant rises the cycle after a test-and-set completes with mem_busy=0. It stays high until rel_req. A release then issues exactly one store (mem_op=2), after which the engine is idle with grant low.
- R9: Once a memory request is raised, mem_req and mem_op stay unchanged until the cycle in which mem_done is high.
- R10: rel_req has no effect unless grant is high: no memory request is issued and grant stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | 1 | Core asks to acquire the lock |
| rel_req | input | 1 | Core releases the held lock |
| grant | output | 1 | Lock is held by this processor |
| cfg_dyn | input | 1 | 1 = random exponential backoff, 0 = static slot |
| cfg_post | input | 1 | 1 = also wait after busy reads and failed test-and-set |
| cfg_slot | input | DW | Static delay value for this processor |
| mem_req | output | 1 | Memory request valid, held until mem_done |
| mem_op | output | 2 | 0 read, 1 test-and-set, 2 store free |
| mem_done | input | 1 | Memory completes the current request this cycle |
| mem_busy | input | 1 | Old lock value returned with mem_done (1 = held) |

## Verification
Assertions check on every cycle that a test-and-set is only issued after a read that returned free. They also check that requests hold their operation until completion, that grant rises only after a successful test-and-set and never overlaps a memory request, that the wait counter falls by one per cycle, and that the exponent stays within its range. Other behaviours can only be shown by the bench scenarios, which compare every cycle against a behavioural model: the exact length of each delay in static and random modes, the exponent growing across repeated stolen test-and-sets and resetting after a win, the fall back to polling when another agent takes the lock between the free read and the re-check, and the spacing that post-access mode adds between busy polls.

// File: rtl/ttas_pkg.sv
`timescale 1ns/1ps
package ttas_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_TAS   = 2'd1,
        OP_STORE = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POLL,
        S_WAIT,
        S_CHK,
        S_TAS,
        S_OWN,
        S_FREE
    } eng_state_e;

    localparam logic [15:0] LFSR_SEED_DEF = 16'hACE1;

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        logic fb;
        fb = v[15] ^ v[13] ^ v[12] ^ v[10];
        return {v[14:0], fb};
    endfunction

endpackage

// File: rtl/ttas_lfsr.sv
`timescale 1ns/1ps
module ttas_lfsr #(
    parameter int          OUTW = 4,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic            clk,
    input  logic            rst,
    output logic [OUTW-1:0] rnd
);
    import ttas_pkg::*;

    logic [15:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_next(state_q);
    end

    assign rnd = state_q[OUTW-1:0];

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != 16'h0000);
endmodule

// File: rtl/ttas_backoff_exp.sv
`timescale 1ns/1ps
module ttas_backoff_exp #(
    parameter int EW      = 3,
    parameter int EXP_MIN = 1,
    parameter int EXP_MAX = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          clr,
    output logic [EW-1:0] expo
);
    localparam logic [EW-1:0] LO = EW'(EXP_MIN);
    localparam logic [EW-1:0] HI = EW'(EXP_MAX);

    logic [EW-1:0] exp_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  exp_q <= LO;
        else if (inc)    exp_q <= (exp_q >= HI) ? HI : exp_q + EW'(1);
    end

    assign expo = exp_q;

    // R7
    exp_range_chk: assert property (@(posedge clk) disable iff (rst)
        exp_q >= LO && exp_q <= HI);

    // R7
    exp_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && exp_q < HI) |=> exp_q == $past(exp_q) + EW'(1));
endmodule

// File: rtl/ttas_delay_pick.sv
`timescale 1ns/1ps
module ttas_delay_pick #(
    parameter int DW = 4,
    parameter int EW = 3
) (
    input  logic          dyn,
    input  logic [DW-1:0] slot,
    input  logic [DW-1:0] rnd,
    input  logic [EW-1:0] expo,
    output logic [DW-1:0] delay
);
    logic [DW-1:0] mask;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < int'(expo));
        end
        delay = dyn ? (rnd & mask) : slot;
    end
endmodule

// File: rtl/ttas_wait_ctr.sv
`timescale 1ns/1ps
module ttas_wait_ctr #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] val,
    input  logic          en,
    output logic          zero
);
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load)                    cnt_q <= val;
        else if (en && cnt_q != '0)       cnt_q <= cnt_q - DW'(1);
    end

    assign zero = (cnt_q == '0);

    // R5
    wait_count_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DW'(1));
endmodule

// File: rtl/ttas_acquire_engine.sv
`timescale 1ns/1ps
module ttas_acquire_engine #(
    parameter int          DW      = 4,
    parameter int          EW      = 3,
    parameter int          EXP_MIN = 1,
    parameter int          EXP_MAX = 4,
    parameter logic [15:0] SEED    = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acq_req,
    input  logic          rel_req,
    output logic          grant,
    input  logic          cfg_dyn,
    input  logic          cfg_post,
    input  logic [DW-1:0] cfg_slot,
    output logic          mem_req,
    output logic [1:0]    mem_op,
    input  logic          mem_done,
    input  logic          mem_busy
);
    import ttas_pkg::*;

    eng_state_e    st_q, st_d;
    logic          ret_q, ret_d;
    logic          load, exp_inc, exp_clr, wait_zero;
    logic [DW-1:0] rnd, delay;
    logic [EW-1:0] expo;
    mem_op_e       op;

    ttas_lfsr #(.OUTW(DW), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .rnd(rnd));

    ttas_backoff_exp #(.EW(EW), .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX)) u_exp (
        .clk(clk), .rst(rst), .inc(exp_inc), .clr(exp_clr), .expo(expo));

    ttas_delay_pick #(.DW(DW), .EW(EW)) u_pick (
        .dyn(cfg_dyn), .slot(cfg_slot), .rnd(rnd), .expo(expo), .delay(delay));

    ttas_wait_ctr #(.DW(DW)) u_wait (
        .clk(clk), .rst(rst), .load(load), .val(delay),
        .en(st_q == S_WAIT), .zero(wait_zero));

    always_comb begin
        st_d    = st_q;
        ret_d   = ret_q;
        load    = 1'b0;
        exp_inc = 1'b0;
        exp_clr = 1'b0;
        unique case (st_q)
            S_IDLE: if (acq_req) st_d = S_POLL;
            S_POLL: if (mem_done) begin
                if (!mem_busy) begin
                    load = 1'b1; ret_d = 1'b1; st_d = S_WAIT;
                end else if (cfg_post) begin
                    load = 1'b1; ret_d = 1'b0; st_d = S_WAIT;
                end
            end
            S_WAIT: if (wait_zero) st_d = ret_q ? S_CHK : S_POLL;
            S_CHK: if (mem_done) begin
                if (!mem_busy) st_d = S_TAS;
                else if (cfg_post) begin
                    load = 1'b1; ret_d = 1'b0; st_d = S_WAIT;
                end else st_d = S_POLL;
            end
            S_TAS: if (mem_done) begin
                if (mem_busy) begin
                    exp_inc = 1'b1;
                    if (cfg_post) begin
                        load = 1'b1; ret_d = 1'b0; st_d = S_WAIT;
                    end else st_d = S_POLL;
                end else begin
                    exp_clr = 1'b1; st_d = S_OWN;
                end
            end
            S_OWN:  if (rel_req) st_d = S_FREE;
            S_FREE: if (mem_done) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            ret_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ret_q <= ret_d;
        end
    end

    always_comb begin
        unique case (st_q)
            S_TAS:   op = OP_TAS;
            S_FREE:  op = OP_STORE;
            default: op = OP_READ;
        endcase
    end

    assign mem_req = (st_q == S_POLL) || (st_q == S_CHK) ||
                     (st_q == S_TAS)  || (st_q == S_FREE);
    assign mem_op  = op;
    assign grant   = (st_q == S_OWN);

    // Port-level record of the last read outcome, used by the checks below.
    logic last_rd_free_q;
    always_ff @(posedge clk) begin
        if (rst) last_rd_free_q <= 1'b0;
        else if (mem_req && mem_done && mem_op == 2'd0) last_rd_free_q <= !mem_busy;
    end

    // R2
    tas_after_free_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_op == 2'd1) |-> last_rd_free_q);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_op)));

    // R8
    grant_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> $past(mem_req && mem_done && mem_op == 2'd1 && !mem_busy));

    // R8
    grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant && mem_req));

    // R8
    store_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_done && mem_op == 2'd2) |=> (!mem_req && !grant));

    // R10
    rel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant && !mem_req && !acq_req) |=> !mem_req);
endmodule

// File: tb/sim_ttas_acquire_engine.sv
`timescale 1ns/1ps
module sim_ttas_acquire_engine;
    logic       clk = 1'b0, rst = 1'b1;
    logic       acq_req = 1'b0, rel_req = 1'b0, cfg_dyn = 1'b0, cfg_post = 1'b0;
    logic [3:0] cfg_slot = 4'd0;
    logic       grant, mem_req;
    logic [1:0] mem_op;
    logic       mem_done = 1'b0, mem_busy = 1'b0;

    always #2 clk = ~clk;

    ttas_acquire_engine u0 (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req), .grant(grant),
        .cfg_dyn(cfg_dyn), .cfg_post(cfg_post), .cfg_slot(cfg_slot),
        .mem_req(mem_req), .mem_op(mem_op), .mem_done(mem_done), .mem_busy(mem_busy));

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    // behavioural model: 0 idle,1 poll,2 wait,3 recheck,4 tas,5 own,6 free
    int m_st = 0, m_cnt = 0, m_e = 1, m_ret = 0, dly = 0;
    logic [15:0] m_lfsr = 16'hACE1;
    int lock = 0, other_hold = 0, mc = 0, steal_chk = 0, steal_tas = 0;
    int n_reads = 0, n_tas = 0, n_tas_fail = 0, n_chk_busy = 0, n_store = 0;
    int gap_clean = -1, gap_busy = -1, last_done_cyc = 0, last_kind = 0;
    logic prev_req = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic string tag_of(input int s);
        case (s)
            0: return "R10";
            1: return "R2";
            2: return cfg_dyn ? "R6" : "R5";
            3: return "R3";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_e = 1; m_ret = 0; m_lfsr = 16'hACE1;
        end else begin
            dly = cfg_dyn ? (int'(m_lfsr[3:0]) & ((1 << m_e) - 1)) : int'(cfg_slot);
            case (m_st)
                0: if (acq_req) m_st = 1;
                1: if (mem_done) begin
                    n_reads++;
                    if (!mem_busy) begin m_cnt = dly; m_ret = 1; m_st = 2; end
                    else if (cfg_post) begin m_cnt = dly; m_ret = 0; m_st = 2; end
                end
                2: if (m_cnt == 0) m_st = m_ret ? 3 : 1; else m_cnt--;
                3: if (mem_done) begin
                    if (!mem_busy) m_st = 4;
                    else begin
                        n_chk_busy++;
                        if (cfg_post) begin m_cnt = dly; m_ret = 0; m_st = 2; end
                        else m_st = 1;
                    end
                end
                4: if (mem_done) begin
                    n_tas++;
                    lock = 1;
                    if (mem_busy) begin
                        n_tas_fail++;
                        m_e = (m_e < 4) ? m_e + 1 : 4;
                        if (cfg_post) begin m_cnt = dly; m_ret = 0; m_st = 2; end
                        else m_st = 1;
                    end else begin
                        m_e = 1; m_st = 5;
                    end
                end
                5: if (rel_req) m_st = 6;
                6: if (mem_done) begin n_store++; lock = 0; m_st = 0; end
                default: m_st = 0;
            endcase
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
        if (other_hold > 0) begin
            other_hold--;
            if (other_hold == 0) lock = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit m_req = (m_st == 1) || (m_st == 3) || (m_st == 4) || (m_st == 6);
            automatic int m_op = (m_st == 4) ? 1 : ((m_st == 6) ? 2 : 0);
            chk(grant == (m_st == 5), "R8", grant, int'(m_st == 5));
            chk(mem_req == m_req, tag_of(m_st), mem_req, m_req);
            if (m_req) chk(int'(mem_op) == m_op, "R9", mem_op, m_op);
            if (mem_req && !prev_req) begin
                if (last_kind == 1) gap_clean = cyc - last_done_cyc;
                if (last_kind == 2) gap_busy = cyc - last_done_cyc;
                last_kind = 0;
            end
            prev_req = mem_req;
            if (mem_req) begin
                if (mc == 1) begin
                    if (steal_chk != 0 && m_st == 3) begin
                        lock = 1; other_hold = 15; steal_chk = 0;
                    end
                    if (steal_tas > 0 && m_st == 4) begin
                        lock = 1; other_hold = 15; steal_tas--;
                    end
                    mem_done = 1'b1;
                    mem_busy = (lock != 0);
                    mc = 0;
                    last_done_cyc = cyc;
                    last_kind = (m_st == 1) ? ((lock == 0) ? 1 : 2) : 0;
                end else begin
                    mc = 1; mem_done = 1'b0;
                end
            end else begin
                mc = 0; mem_done = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog R8 actual=timeout expected=grant");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_st(input int s);
        while (m_st != s) @(negedge clk);
    endtask

    task automatic do_release();
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        wait_st(0);
        @(negedge clk);
    endtask

    initial begin
        int base, base2;
        repeat (3) @(negedge clk);
        chk(grant == 1'b0, "R1", grant, 0);
        chk(mem_req == 1'b0, "R1", mem_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(grant == 1'b0 && mem_req == 1'b0, "R1", {grant, mem_req}, 0);

        // static slot, lock held by another agent for a while
        cfg_slot = 4'd3; lock = 1; other_hold = 30; gap_clean = -1;
        base = n_tas; acq_req = 1'b1;
        wait_st(5);
        acq_req = 1'b0;
        chk(n_tas - base == 1, "R2", n_tas - base, 1);
        chk(n_reads >= 4, "R2", n_reads, 4);
        chk(gap_clean == 5, "R5", gap_clean, 5);
        repeat (4) @(negedge clk);
        chk(grant == 1'b1, "R8", grant, 1);
        do_release();
        chk(lock == 0, "R8", lock, 0);
        chk(n_store == 1, "R8", n_store, 1);
        chk(grant == 1'b0, "R8", grant, 0);

        // release while not granted
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        begin
            automatic int seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (mem_req || grant) seen++;
            end
            chk(seen == 0, "R10", seen, 0);
        end

        // lock taken between free read and re-check
        cfg_slot = 4'd1; steal_chk = 1;
        base = n_tas; base2 = n_chk_busy; acq_req = 1'b1;
        wait_st(5);
        acq_req = 1'b0;
        chk(n_chk_busy - base2 == 1, "R3", n_chk_busy - base2, 1);
        chk(n_tas - base == 1, "R3", n_tas - base, 1);
        do_release();

        // random exponential backoff with repeated stolen test-and-set
        cfg_dyn = 1'b1; steal_tas = 5;
        base = n_tas_fail; acq_req = 1'b1;
        wait_st(5);
        acq_req = 1'b0;
        chk(n_tas_fail - base == 5, "R7", n_tas_fail - base, 5);
        do_release();
        gap_clean = -1; acq_req = 1'b1;
        wait_st(5);
        acq_req = 1'b0;
        chk(gap_clean >= 2 && gap_clean <= 3, "R7", gap_clean, 2);
        chk(gap_clean - 2 == (gap_clean - 2) % 2, "R6", gap_clean - 2, 1);
        do_release();

        // post-access delay between busy polls
        cfg_dyn = 1'b0; cfg_post = 1'b1; cfg_slot = 4'd2;
        lock = 1; other_hold = 25; gap_busy = -1; acq_req = 1'b1;
        wait_st(5);
        acq_req = 1'b0;
        chk(gap_busy == 4, "R4", gap_busy, 4);
        do_release();
        chk(grant == 1'b0 && mem_req == 1'b0, "R8", {grant, mem_req}, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule